// File: doc/BRIEF.md
# Stop-Mode Clock Gate and Wake-Up Restart Sequencer

This block owns the core clock while the processor sleeps in its deepest low-power state. A single-cycle stop request from software gates the core clock off and shuts down every oscillator the core could run from. While halted, the block watches a vector of pending external interrupts against their enable bits. The first enabled, pending interrupt restarts the core and raises a one-cycle wake pulse so that the interrupt is serviced and execution resumes after the stop point. An external reset also ends the halt, and its release returns the block to its reset state.

On an interrupt wake-up the clock restart follows a configuration bit. With the bit clear, the selected main source (crystal or RC, picked by a second bit) is powered up. The internal ring oscillator clocks the core while a warm-up timer of `WARM_CYCLES` cycles runs. When the timer expires, the core is handed over to the main source and the ring is turned off. A status output reports that the handover has happened. With the bit set, the core stays on the ring oscillator and the main source stays powered down.

A brownout reset request is passed through, except while halted with the brownout-masking option set.

The sequencer itself runs on an always-on clock `clk`. The oscillator enables and the core clock enable are the outputs to the clock tree.

Top module: `stop_clk_seq`

## Requirements
- R1: While reset is asserted and after it is released, the core clock is enabled and runs from the main source (`core_on_main`=1). The main source selected by `src_xtal` is enabled, the ring oscillator is off, and `wake_irq` is 0.
- R2: A `stop_req` sampled high in any running state makes `cpu_clk_en`, `ring_osc_en`, `xt_osc_en` and `rc_osc_en` all 0 from the next cycle.
- R3: While halted, further `stop_req` pulses have no effect: the core clock stays off.
- R4: While halted, an interrupt that is pending (`irq_pend[i]`=1) but not enabled (`irq_en[i]`=0) does not wake the block.
- R5: While halted, any bit set in both `irq_pend` and `irq_en` re-enables `cpu_clk_en` from the next cycle. In that same cycle `wake_irq` is 1, and it is 1 for exactly one cycle.
- R6: On a wake with `ring_keep`=0, the core runs from the ring (`ring_osc_en`=1, `core_on_main`=0) with the main source enabled for exactly `WARM_CYCLES` cycles. After that, `core_on_main`=1 and `ring_osc_en`=0.
- R7: On a wake with `ring_keep`=1, the core runs from the ring indefinitely. `core_on_main` stays 0 and both main-source enables stay 0.
- R8: The main-source enable goes to `xt_osc_en` when `src_xtal`=1 and to `rc_osc_en` when `src_xtal`=0, never to both.
- R9: `bod_rst` follows `bod_trip`, except that it is 0 while halted with `bod_mask_stop`=1.
- R10: A stop request during warm-up halts the core. A later wake restarts the full `WARM_CYCLES` warm-up.
- R11: Asserting `rst_n` while halted turns the core clock back on at once from the main source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | Single-cycle request to enter stop |
| irq_pend | input | N_IRQ | Pending external interrupt lines |
| irq_en | input | N_IRQ | Per-line interrupt enables |
| ring_keep | input | 1 | 1: stay on ring after wake; 0: warm up and hand over |
| src_xtal | input | 1 | Main source select: 1 crystal, 0 RC |
| bod_mask_stop | input | 1 | Suppress brownout reset while halted |
| bod_trip | input | 1 | Brownout detector output |
| cpu_clk_en | output | 1 | Core clock enable |
| core_on_main | output | 1 | Status: core runs from main source |
| ring_osc_en | output | 1 | Ring oscillator enable |
| xt_osc_en | output | 1 | Crystal oscillator enable |
| rc_osc_en | output | 1 | RC oscillator enable |
| wake_irq | output | 1 | One-cycle pulse on interrupt wake-up |
| bod_rst | output | 1 | Brownout reset request |

## Verification
The sequencer state is one register stage. A stop request or a wake sampled at an edge shows on `cpu_clk_en`, the oscillator enables and `wake_irq` during the cycle that edge opens. The handover to the main source comes exactly `WARM_CYCLES` cycles after the warm-up begins. The main-source selection and `bod_rst` are combinational from the current state and inputs, so they are due in the same cycle. Asserting the asynchronous reset forces the outputs at once. The bench drives inputs one nanosecond after the falling edge and compares every output with its behavioural model at each falling edge, so each result is read in the cycle it is due. Dedicated checks count the warm-up cycles directly.

// File: rtl/stop_clk_seq_pkg.sv
package stop_clk_seq_pkg;
  typedef enum logic [1:0] {
    SQ_MAIN = 2'd0,
    SQ_HALT = 2'd1,
    SQ_WARM = 2'd2,
    SQ_RING = 2'd3
  } sq_state_t;
endpackage

// File: rtl/scs_rst_sync.sv
module scs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/scs_warm_timer.sv
module scs_warm_timer #(
  parameter int WARM_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CNT_W = (WARM_CYCLES > 2) ? $clog2(WARM_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WARM_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!run) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q != LAST) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = run && (cnt_q == LAST);
endmodule

// File: rtl/scs_stop_fsm.sv
module scs_stop_fsm
  import stop_clk_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      stop_req,
  input  logic      wake,
  input  logic      ring_keep,
  input  logic      warm_done,
  output sq_state_t state,
  output logic      wake_pulse
);
  sq_state_t st_q, st_d;
  logic      pulse_q, pulse_d;

  always_comb begin
    st_d    = st_q;
    pulse_d = 1'b0;
    unique case (st_q)
      SQ_HALT: begin
        if (wake) begin
          st_d    = ring_keep ? SQ_RING : SQ_WARM;
          pulse_d = 1'b1;
        end
      end
      SQ_WARM: begin
        if (stop_req)       st_d = SQ_HALT;
        else if (warm_done) st_d = SQ_MAIN;
      end
      default: begin
        if (stop_req) st_d = SQ_HALT;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_MAIN;
      pulse_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      pulse_q <= pulse_d;
    end
  end

  assign state      = st_q;
  assign wake_pulse = pulse_q;
endmodule

// File: rtl/stop_clk_seq.sv
module stop_clk_seq
  import stop_clk_seq_pkg::*;
#(
  parameter int N_IRQ       = 4,
  parameter int WARM_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_req,
  input  logic [N_IRQ-1:0] irq_pend,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             ring_keep,
  input  logic             src_xtal,
  input  logic             bod_mask_stop,
  input  logic             bod_trip,
  output logic             cpu_clk_en,
  output logic             core_on_main,
  output logic             ring_osc_en,
  output logic             xt_osc_en,
  output logic             rc_osc_en,
  output logic             wake_irq,
  output logic             bod_rst
);
  logic      rst_sync_n;
  logic      wake_any;
  logic      warm_done;
  logic      main_en;
  sq_state_t state;

  scs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk   (clk),
    .arst_n(rst_n),
    .srst_n(rst_sync_n)
  );

  assign wake_any = |(irq_pend & irq_en);

  scs_warm_timer #(.WARM_CYCLES(WARM_CYCLES)) u_timer (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .run  (state == SQ_WARM),
    .done (warm_done)
  );

  scs_stop_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .stop_req  (stop_req),
    .wake      (wake_any),
    .ring_keep (ring_keep),
    .warm_done (warm_done),
    .state     (state),
    .wake_pulse(wake_irq)
  );

  always_comb begin
    cpu_clk_en   = (state != SQ_HALT);
    core_on_main = (state == SQ_MAIN);
    ring_osc_en  = (state == SQ_WARM) || (state == SQ_RING);
    main_en      = (state == SQ_MAIN) || (state == SQ_WARM);
    xt_osc_en    = main_en &&  src_xtal;
    rc_osc_en    = main_en && !src_xtal;
    bod_rst      = bod_trip && !((state == SQ_HALT) && bod_mask_stop);
  end
endmodule

// File: rtl/stop_clk_seq_chk.sv
module stop_clk_seq_chk #(
  parameter int N_IRQ = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop_req,
  input logic [N_IRQ-1:0] irq_pend,
  input logic [N_IRQ-1:0] irq_en,
  input logic             ring_keep,
  input logic             bod_mask_stop,
  input logic             cpu_clk_en,
  input logic             core_on_main,
  input logic             ring_osc_en,
  input logic             xt_osc_en,
  input logic             rc_osc_en,
  input logic             wake_irq,
  input logic             bod_rst
);
  logic hit;
  assign hit = |(irq_pend & irq_en);

  assert_stop_gates_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && cpu_clk_en) |=> (!cpu_clk_en && !ring_osc_en && !xt_osc_en && !rc_osc_en));

  assert_stop_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && stop_req && !hit) |=> !cpu_clk_en);

  assert_masked_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && !hit) |=> !cpu_clk_en);

  assert_wake_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && hit) |=> (cpu_clk_en && wake_irq));

  assert_wake_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |=> !wake_irq);

  assert_wake_from_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> $past(!cpu_clk_en));

  assert_main_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    core_on_main |-> (!ring_osc_en && (xt_osc_en || rc_osc_en)));

  assert_handover_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_on_main) |-> $past(ring_osc_en && (xt_osc_en || rc_osc_en)));

  assert_ring_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && hit && ring_keep) |=> (ring_osc_en && !core_on_main && !xt_osc_en && !rc_osc_en));

  assert_one_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(xt_osc_en && rc_osc_en));

  assert_bod_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && bod_mask_stop) |-> !bod_rst);
endmodule

bind stop_clk_seq stop_clk_seq_chk #(.N_IRQ(N_IRQ)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .stop_req     (stop_req),
  .irq_pend     (irq_pend),
  .irq_en       (irq_en),
  .ring_keep    (ring_keep),
  .bod_mask_stop(bod_mask_stop),
  .cpu_clk_en   (cpu_clk_en),
  .core_on_main (core_on_main),
  .ring_osc_en  (ring_osc_en),
  .xt_osc_en    (xt_osc_en),
  .rc_osc_en    (rc_osc_en),
  .wake_irq     (wake_irq),
  .bod_rst      (bod_rst)
);

// File: tb/tb_stop_clk_seq.sv
module tb_stop_clk_seq;
  localparam int NI = 4;
  localparam int WC = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic          stop_req, ring_keep, src_xtal, bod_mask_stop, bod_trip;
  logic [NI-1:0] irq_pend, irq_en;
  logic          cpu_clk_en, core_on_main, ring_osc_en, xt_osc_en, rc_osc_en, wake_irq, bod_rst;

  stop_clk_seq #(.N_IRQ(NI), .WARM_CYCLES(WC)) dut (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .irq_pend(irq_pend), .irq_en(irq_en),
    .ring_keep(ring_keep), .src_xtal(src_xtal), .bod_mask_stop(bod_mask_stop), .bod_trip(bod_trip),
    .cpu_clk_en(cpu_clk_en), .core_on_main(core_on_main), .ring_osc_en(ring_osc_en),
    .xt_osc_en(xt_osc_en), .rc_osc_en(rc_osc_en), .wake_irq(wake_irq), .bod_rst(bod_rst)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit cmp_on = 1'b0;

  // Behavioural model: 0 main, 1 halted, 2 warming on ring, 3 ring only
  int mst  = 0;
  int mcnt = 0;
  bit mwake = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge rst_n) begin
    mst = 0; mcnt = 0; mwake = 1'b0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      mst = 0; mcnt = 0; mwake = 1'b0;
    end else begin
      mwake = 1'b0;
      if (mst == 1) begin
        if ((irq_pend & irq_en) != 0) begin
          mst = ring_keep ? 3 : 2; mcnt = 0; mwake = 1'b1;
        end
      end else if (stop_req) begin
        mst = 1; mcnt = 0;
      end else if (mst == 2) begin
        if (mcnt == WC - 1) begin mst = 0; mcnt = 0; end
        else mcnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      int main_on;
      main_on = (mst == 0 || mst == 2) ? 1 : 0;
      chk("R2 cpu_clk_en", cpu_clk_en, (mst != 1) ? 1 : 0);
      chk("R6 core_on_main", core_on_main, (mst == 0) ? 1 : 0);
      chk("R7 ring_osc_en", ring_osc_en, (mst == 2 || mst == 3) ? 1 : 0);
      chk("R8 xt_osc_en", xt_osc_en, main_on & int'(src_xtal));
      chk("R8 rc_osc_en", rc_osc_en, main_on & int'(!src_xtal));
      chk("R5 wake_irq", wake_irq, int'(mwake));
      chk("R9 bod_rst", bod_rst, int'(bod_trip && !(mst == 1 && bod_mask_stop)));
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<20000", wd);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic measure_warm(input string tag);
    int w = 0;
    while (!core_on_main && ring_osc_en && w < 1000) begin
      w++;
      step(1);
    end
    chk(tag, w, WC);
  endtask

  initial begin
    rst_n = 1'b0; stop_req = 1'b0; ring_keep = 1'b0; src_xtal = 1'b1;
    bod_mask_stop = 1'b0; bod_trip = 1'b0; irq_pend = '0; irq_en = '0;
    #2 cmp_on = 1'b1;
    step(3);
    chk("R1 cpu_clk_en", cpu_clk_en, 1);
    chk("R1 core_on_main", core_on_main, 1);
    chk("R1 xt_osc_en", xt_osc_en, 1);
    chk("R1 ring_osc_en", ring_osc_en, 0);
    chk("R1 wake_irq", wake_irq, 0);
    rst_n = 1'b1;
    step(4);
    chk("R1 after release", core_on_main, 1);

    stop_req = 1'b1; step(1); stop_req = 1'b0;
    chk("R2 halted", cpu_clk_en, 0);
    chk("R2 osc off", int'(xt_osc_en | rc_osc_en | ring_osc_en), 0);

    stop_req = 1'b1; step(3); stop_req = 1'b0;
    chk("R3 repeat stop", cpu_clk_en, 0);

    irq_pend = 4'b1010; irq_en = 4'b0101; step(4);
    chk("R4 masked irq", cpu_clk_en, 0);

    irq_en = 4'b0010; step(1); irq_pend = '0; irq_en = '0;
    chk("R5 woke", cpu_clk_en, 1);
    chk("R5 pulse", wake_irq, 1);
    measure_warm("R6 warm length");
    chk("R6 handover", core_on_main, 1);
    chk("R6 ring off", ring_osc_en, 0);

    src_xtal = 1'b0; step(1);
    chk("R8 rc sel", rc_osc_en, 1);
    chk("R8 xt off", xt_osc_en, 0);
    src_xtal = 1'b1; step(1);
    chk("R8 xt sel", xt_osc_en, 1);

    stop_req = 1'b1; step(1); stop_req = 1'b0;
    ring_keep = 1'b1; irq_pend = 4'b0001; irq_en = 4'b0001; step(1); irq_pend = '0;
    step(30);
    chk("R7 on ring", ring_osc_en, 1);
    chk("R7 main off", int'(xt_osc_en | rc_osc_en | core_on_main), 0);

    stop_req = 1'b1; step(1); stop_req = 1'b0;
    ring_keep = 1'b0; irq_pend = 4'b1000; irq_en = 4'b1000; step(1); irq_pend = '0;
    step(5);
    chk("R10 warming", int'(ring_osc_en && !core_on_main), 1);
    stop_req = 1'b1; step(1); stop_req = 1'b0;
    chk("R10 halted in warm", cpu_clk_en, 0);
    step(3);
    irq_pend = 4'b0100; irq_en = 4'b0100; step(1); irq_pend = '0;
    measure_warm("R10 full restart");

    bod_trip = 1'b1; step(1);
    chk("R9 run trip", bod_rst, 1);
    stop_req = 1'b1; step(1); stop_req = 1'b0;
    chk("R9 halt unmasked", bod_rst, 1);
    bod_mask_stop = 1'b1; step(1);
    chk("R9 halt masked", bod_rst, 0);

    rst_n = 1'b0; #1;
    chk("R11 reset wakes", cpu_clk_en, 1);
    chk("R11 on main", core_on_main, 1);
    step(2);
    rst_n = 1'b1; bod_trip = 1'b0; bod_mask_stop = 1'b0; step(5);
    chk("R11 after release", int'(cpu_clk_en && core_on_main), 1);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule